// File: doc/BRIEF.md
# Delay-Line Clock Alignment Controller

This block is the digital half of a feedback clock aligner. An output clock leaves the chip through a 128-cell delay line, and one copy of it comes back. The block samples that returned copy on the rising edge of its own reference clock. The sampled bit passes through a synchronizer chain. The block then nudges a 7-bit delay count up or down by one cell, so that the output clock's edge moves toward the reference edge. The count is decoded into two select lines per cell, one from a row decoder and one from a column decoder. The cell where both lines are high is the injection point of the line.

The loop is bang-bang. It has no "aligned" indication. At lock it keeps stepping back and forth between two neighbouring counts, and it keeps running so that it follows slow drift. After each step it waits until the synchronizer has carried a sample taken with the new count, so that it never acts on stale data. Automatic mode is off after reset. Software can turn it on, or keep it off and load a count directly. Two feedback inputs are provided, and the one to use is picked by a strap that is sampled while reset is high. The current count and the synchronized phase bit are brought out as status.

Top module: `clk_align_ctrl`

## Requirements
- R1: During and right after reset, `dly_cnt` is 0, `phase_bit` is 0 and automatic mode is idle. The cell selects point at cell 0: `cell_row[i]` is high only for i in 0..7, and `cell_col[i]` is high only where i mod 8 is 0.
- R2: A feedback level applied before a rising edge of `clk` shows up on `phase_bit` after exactly 8 rising edges: one detector flop followed by 7 synchronizing flops. It is not visible after 7 edges.
- R3: In automatic mode, a synchronized phase bit of 1 means the feedback clock leads, and the next step adds one to the count. A phase bit of 0 means it trails, and the next step subtracts one. The count never changes by more than one per step.
- R4: In automatic mode, steps are 9 cycles apart, which is the synchronizer depth plus one. Once `auto_en` is raised, the first step occurs on the 9th rising edge.
- R5: With a feedback phase that reverses at one point, the count settles into alternating between the two neighbouring values that straddle that point. It uses only those two values.
- R6: The count saturates at 127 when the feedback keeps leading, and at 0 when it keeps trailing. It never wraps.
- R7: When `auto_en` is low, a one-cycle `force_we` loads `force_val` into `dly_cnt` on that rising edge. When `auto_en` is high, `force_we` has no effect on the count.
- R8: When `auto_en` is low and `force_we` is low, `dly_cnt` holds its value whatever the feedback does.
- R9: One cycle after the count changes, `cell_row[i]` is high exactly when bits 6..3 of i equal bits 6..3 of the count, and `cell_col[i]` is high exactly when bits 2..0 of i equal bits 2..0 of the count. Exactly one cell has both lines high, and its index is the count.
- R10: `det_sel` is captured while `rst` is high. A value of 0 selects `fb_clk_a` and a value of 1 selects `fb_clk_b`. Changing `det_sel` after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the phase detectors |
| rst | input | 1 | Synchronous active-high reset |
| fb_clk_a | input | 1 | Fed-back output clock, detector input 0 |
| fb_clk_b | input | 1 | Fed-back output clock, detector input 1 |
| det_sel | input | 1 | Detector input choice, captured during reset |
| auto_en | input | 1 | Enables automatic alignment |
| force_we | input | 1 | Loads `force_val` into the count while automatic mode is off |
| force_val | input | 7 | Count value to load |
| dly_cnt | output | 7 | Current delay count (status) |
| phase_bit | output | 1 | Synchronized phase sample (status) |
| cell_row | output | 128 | Per-cell select from the row (upper bits) decoder |
| cell_col | output | 128 | Per-cell select from the column (lower bits) decoder |

## Verification
The bench models the delay line as a fixed offset plus 200 ps per cell, taken modulo a 4 ns period. It feeds back the level the detector would sample. Starting counts on each side of the lock point show that the direction of each step follows the phase. Counting cycles between steps separates a correct flush wait from an early or late step. A constant-level feedback at count 0 and count 127 exposes wrap-around. Forced counts show the decode placement, and also that force writes are ignored in automatic mode. Routing the model to one detector input while the other input is held constant shows which input the reset strap selected.

// File: rtl/clk_align_pkg.sv
package clk_align_pkg;
  localparam int CNT_W_DEF      = 7;
  localparam int ROW_W_DEF      = 4;
  localparam int SYNC_DEPTH_DEF = 8;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/clk_align_sync.sv
module clk_align_sync #(
  parameter int SYNC_DEPTH = clk_align_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_a,
  input  logic fb_b,
  input  logic det_sel,
  output logic phase
);
  localparam int CHAIN = SYNC_DEPTH - 1;

  logic [1:0]       fb_in;
  logic [1:0]       det_q;
  logic             sel_q;
  logic [CHAIN-1:0] chain_q;

  assign fb_in = {fb_b, fb_a};

  // strap is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) sel_q <= det_sel;
  end

  // two alternative detector flops, one per feedback input
  for (genvar k = 0; k < 2; k++) begin : g_det
    always_ff @(posedge clk) begin
      if (rst) det_q[k] <= 1'b0;
      else     det_q[k] <= fb_in[k];
    end
  end

  // hardening chain behind the chosen detector
  for (genvar s = 0; s < CHAIN; s++) begin : g_chain
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= det_q[sel_q];
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= 1'b0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign phase = chain_q[CHAIN-1];

  a_r10_strap_locked: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(sel_q));
endmodule

// File: rtl/clk_align_step.sv
module clk_align_step
  import clk_align_pkg::*;
#(
  parameter int CNT_W      = CNT_W_DEF,
  parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase,
  input  logic             auto_en,
  input  logic             force_we,
  input  logic [CNT_W-1:0] force_val,
  output logic [CNT_W-1:0] cnt
);
  localparam int              SETTLE = SYNC_DEPTH;
  localparam int              HOLD_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] MAXC  = {CNT_W{1'b1}};

  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q;
  step_e             dir;

  always_comb begin
    dir = STEP_HOLD;
    if (auto_en && hold_q == '0) begin
      if (phase) dir = (cnt_q == MAXC)   ? STEP_HOLD : STEP_UP;
      else       dir = (cnt_q == '0)     ? STEP_HOLD : STEP_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= HOLD_W'(SETTLE);
    end else if (!auto_en) begin
      hold_q <= HOLD_W'(SETTLE);
      if (force_we) cnt_q <= force_val;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else begin
      hold_q <= HOLD_W'(SETTLE);
      case (dir)
        STEP_UP:   cnt_q <= cnt_q + 1'b1;
        STEP_DOWN: cnt_q <= cnt_q - 1'b1;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt = cnt_q;

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    $past(auto_en) |-> ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} ||
                        {1'b0, cnt_q} == {1'b0, $past(cnt_q)} + 1'b1 ||
                        {1'b0, cnt_q} + 1'b1 == {1'b0, $past(cnt_q)}));
  a_r4_quiet_after_step: assert property (@(posedge clk) disable iff (rst)
    (auto_en && $past(auto_en) && !$stable(cnt_q)) |=> $stable(cnt_q));
  a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
    ($past(auto_en) && $past(cnt_q) == MAXC) |-> cnt_q != '0);
  a_r6_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
    ($past(auto_en) && $past(cnt_q) == '0) |-> cnt_q != MAXC);
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && !force_we) |=> $stable(cnt_q));
endmodule

// File: rtl/clk_align_decode.sv
module clk_align_decode #(
  parameter int CNT_W = clk_align_pkg::CNT_W_DEF,
  parameter int ROW_W = clk_align_pkg::ROW_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cnt,
  output logic [2**CNT_W-1:0] sel_row,
  output logic [2**CNT_W-1:0] sel_col
);
  localparam int COL_W = CNT_W - ROW_W;
  localparam int ROWS  = 2**ROW_W;
  localparam int COLS  = 2**COL_W;
  localparam int CELLS = 2**CNT_W;

  logic [ROWS-1:0] row_q;
  logic [COLS-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= ROWS'(1);
      col_q <= COLS'(1);
    end else begin
      row_q <= ROWS'(1) << cnt[CNT_W-1:COL_W];
      col_q <= COLS'(1) << cnt[COL_W-1:0];
    end
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign sel_row[i] = row_q[i / COLS];
    assign sel_col[i] = col_q[i % COLS];
  end

  a_r9_one_row: assert property (@(posedge clk) disable iff (rst)
    $countones(row_q) == 1);
  a_r9_one_col: assert property (@(posedge clk) disable iff (rst)
    $countones(col_q) == 1);
  a_r9_row_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> row_q[$past(cnt[CNT_W-1:COL_W])]);
  a_r9_one_cell: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_row & sel_col) == 1);
endmodule

// File: rtl/clk_align_ctrl.sv
module clk_align_ctrl
  import clk_align_pkg::*;
#(
  parameter int CNT_W      = CNT_W_DEF,
  parameter int ROW_W      = ROW_W_DEF,
  parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fb_clk_a,
  input  logic                fb_clk_b,
  input  logic                det_sel,
  input  logic                auto_en,
  input  logic                force_we,
  input  logic [CNT_W-1:0]    force_val,
  output logic [CNT_W-1:0]    dly_cnt,
  output logic                phase_bit,
  output logic [2**CNT_W-1:0] cell_row,
  output logic [2**CNT_W-1:0] cell_col
);
  logic             phase_s;
  logic [CNT_W-1:0] cnt_s;

  clk_align_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .fb_a(fb_clk_a), .fb_b(fb_clk_b),
    .det_sel(det_sel), .phase(phase_s));

  clk_align_step #(.CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) u_step (
    .clk(clk), .rst(rst), .phase(phase_s), .auto_en(auto_en),
    .force_we(force_we), .force_val(force_val), .cnt(cnt_s));

  clk_align_decode #(.CNT_W(CNT_W), .ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst(rst), .cnt(cnt_s),
    .sel_row(cell_row), .sel_col(cell_col));

  assign dly_cnt   = cnt_s;
  assign phase_bit = phase_s;

  a_r1_reset_count: assert property (@(posedge clk)
    $past(rst) |-> dly_cnt == '0);
endmodule

// File: tb/sim_clk_align_ctrl.sv
`timescale 1ps/1ps
module sim_clk_align_ctrl;
  localparam int PER = 4000;
  localparam int CELL_PS = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_clk_a = 1'b0, fb_clk_b = 1'b0;
  logic det_sel = 1'b0, auto_en = 1'b0, force_we = 1'b0;
  logic [6:0] force_val = '0;
  logic [6:0] dly_cnt;
  logic phase_bit;
  logic [127:0] cell_row, cell_col;

  int checks = 0, errors = 0;
  int off_ps = 1100;
  int mode_a = 0;   // 0 model, 1 const 0, 2 const 1
  int mode_b = 1;

  always #(PER/2) clk = ~clk;

  clk_align_ctrl u0 (
    .clk(clk), .rst(rst), .fb_clk_a(fb_clk_a), .fb_clk_b(fb_clk_b),
    .det_sel(det_sel), .auto_en(auto_en), .force_we(force_we),
    .force_val(force_val), .dly_cnt(dly_cnt), .phase_bit(phase_bit),
    .cell_row(cell_row), .cell_col(cell_col));

  // delay-line model: level of the returned clock at the reference edge
  always begin
    @(negedge clk);
    #1;
    begin
      int t;
      logic smp;
      t = off_ps + int'(dly_cnt) * CELL_PS;
      smp = (t % PER) > (PER / 2);
      fb_clk_a = (mode_a == 0) ? smp : (mode_a == 2);
      fb_clk_b = (mode_b == 0) ? smp : (mode_b == 2);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1; auto_en = 1'b0; force_we = 1'b0; det_sel = strap;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic force_cnt(input int v);
    force_val = 7'(v); force_we = 1'b1;
    tick(1);
    force_we = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk(dly_cnt == 0, "R1 count", int'(dly_cnt), 0);
    chk(phase_bit == 0, "R1 phase", int'(phase_bit), 0);
    chk(cell_row == 128'hFF, "R1 row", int'(cell_row[15:0]), 255);
    chk(cell_col == {16{8'h01}}, "R1 col", int'(cell_col[15:0]), 257);
  endtask

  task automatic t_chain_latency;
    do_reset(1'b0);
    mode_a = 1; tick(12);
    mode_a = 2; tick(1);  // detector sees 1 from next edge
    tick(6);
    chk(phase_bit == 0, "R2 not after 7 edges", int'(phase_bit), 0);
    tick(1);
    chk(phase_bit == 1, "R2 after 8 edges", int'(phase_bit), 1);
    mode_a = 0;
  endtask

  task automatic t_force_decode;
    do_reset(1'b0);
    force_cnt(77);
    chk(dly_cnt == 77, "R7 force load", int'(dly_cnt), 77);
    tick(1);
    begin
      int both, idx;
      both = 0; idx = -1;
      for (int i = 0; i < 128; i++) begin
        if (cell_row[i] && cell_col[i]) begin both++; idx = i; end
        chk(cell_row[i] == ((i >> 3) == (77 >> 3)), "R9 row line", int'(cell_row[i]), int'((i >> 3) == 9));
        chk(cell_col[i] == ((i & 7) == 5), "R9 col line", int'(cell_col[i]), int'((i & 7) == 5));
      end
      chk(both == 1 && idx == 77, "R9 injection cell", idx, 77);
    end
  endtask

  task automatic t_disabled_hold;
    do_reset(1'b0);
    mode_a = 0; off_ps = 1100;
    force_cnt(40);
    tick(40);
    chk(dly_cnt == 40, "R8 hold when off", int'(dly_cnt), 40);
  endtask

  task automatic t_pace_down;
    do_reset(1'b0);
    mode_a = 0; off_ps = 1100;
    force_cnt(40); tick(2);
    auto_en = 1'b1;
    tick(8);
    chk(dly_cnt == 40, "R4 no step before 9th edge", int'(dly_cnt), 40);
    tick(1);
    chk(dly_cnt == 39, "R3 trailing steps down", int'(dly_cnt), 39);
    tick(8);
    chk(dly_cnt == 39, "R4 quiet between steps", int'(dly_cnt), 39);
    tick(1);
    chk(dly_cnt == 38, "R4 next step at 9 cycles", int'(dly_cnt), 38);
    auto_en = 1'b0;
  endtask

  task automatic t_step_up;
    do_reset(1'b0);
    mode_a = 0; off_ps = 1100;
    force_cnt(45); tick(2);
    auto_en = 1'b1;
    tick(9);
    chk(dly_cnt == 46, "R3 leading steps up", int'(dly_cnt), 46);
    tick(200);
    chk(dly_cnt == 54 || dly_cnt == 55, "R5 lock from below", int'(dly_cnt), 54);
    auto_en = 1'b0;
  endtask

  task automatic lock_window(input string req, input int lo);
    int n_lo, n_hi, n_other;
    n_lo = 0; n_hi = 0; n_other = 0;
    for (int i = 0; i < 45; i++) begin
      tick(1);
      if (dly_cnt == 7'(lo)) n_lo++;
      else if (dly_cnt == 7'(lo + 1)) n_hi++;
      else n_other++;
    end
    chk(n_other == 0, req, n_other, 0);
    chk(n_lo > 0 && n_hi > 0, req, n_lo * 100 + n_hi, 1);
  endtask

  task automatic t_lock;
    do_reset(1'b0);
    mode_a = 0; off_ps = 1100;
    force_cnt(40); tick(1);
    auto_en = 1'b1;
    tick(200);
    lock_window("R5 dither 34/35", 34);
    auto_en = 1'b0;
  endtask

  task automatic t_saturate;
    do_reset(1'b0);
    mode_a = 2;
    force_cnt(126); tick(1);
    auto_en = 1'b1;
    tick(60);
    chk(dly_cnt == 127, "R6 saturate high", int'(dly_cnt), 127);
    force_val = 7'd10; force_we = 1'b1; tick(1); force_we = 1'b0;
    tick(1);
    chk(dly_cnt == 127, "R7 force ignored in auto", int'(dly_cnt), 127);
    auto_en = 1'b0; tick(1);
    mode_a = 1;
    force_cnt(1); tick(1);
    auto_en = 1'b1;
    tick(60);
    chk(dly_cnt == 0, "R6 saturate low", int'(dly_cnt), 0);
    auto_en = 1'b0;
    mode_a = 0;
  endtask

  task automatic t_detsel;
    mode_a = 2; mode_b = 0; off_ps = 1100;
    do_reset(1'b1);
    force_cnt(40); tick(1);
    det_sel = 1'b0;  // ignored after reset
    auto_en = 1'b1;
    tick(200);
    lock_window("R10 input b selected", 34);
    auto_en = 1'b0;
    mode_a = 0; mode_b = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_chain_latency();
    t_force_decode();
    t_disabled_hold();
    t_pace_down();
    t_step_up();
    t_lock();
    t_saturate();
    t_detsel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule